// File: doc/BRIEF.md
# Interlocked Four-Phase Bus Transfer Engine

This block runs single transfers over a bus whose two sides share no timing. Each transfer is paced by two strobes. The master raises a master strobe, and the addressed slave answers with a slave strobe. Each side waits to see the other's strobe change before it moves on, so the two ends may run at any relative speed. The top module holds one master engine and one slave engine, joined by a shared bus. Every bus line is also brought out to ports, so a transfer can be observed line by line.

Local logic asks for a transfer with a one-cycle start pulse. It gives a direction, an address and write data. The master waits for the bus grant from an outside arbiter and then runs the handshake. It raises a one-cycle done pulse, with an error flag and any read data, only after both strobes have dropped.

The slave decodes a window of addresses. It turns each accepted transfer into a register-style access on its local side. A read uses a combinational read port. A write produces a one-cycle write strobe. If nothing answers within a programmable number of cycles, the master gives up and reports a bus error.

Top module: `abus_link`

## Requirements
- R1: After the bus grant is seen, the master raises bus-busy, the address, the direction code and the master strobe in the same cycle. Before the grant, none of these leave their idle level of zero.
- R2: On a write, the master drives the write data onto the bus data lines in the same cycle that it drops the master strobe. It keeps the data there until the slave strobe falls. The slave then issues exactly one local write strobe that carries the address offset and that data.
- R3: On a read, the slave places the word from its local read port on the bus data lines in the cycle that it raises the slave strobe. The master returns that word on `rdata` together with done.
- R4: The master holds the master strobe high until it sees the slave strobe, unless it aborts. The slave drops the slave strobe only after it has seen the master strobe low.
- R5: The done pulse comes only while both strobes are low. Bus-busy is released in the same cycle.
- R6: The bus direction code is 1 for a read and 0 for a write.
- R7: The slave answers only when address bits [AW-1:OFF_W] equal those bits of BASE. The low OFF_W bits are the offset on the local port. On any other address the slave strobe stays low.
- R8: If no slave strobe is seen within `timeout` cycles of raising the master strobe, the master drops the strobe. It then completes with `err` = 1, and no local write takes place.
- R9: Out of reset, all bus lines, done, busy and the local write strobe are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that requests a transfer |
| rd | input | 1 | Direction of the request: 1 read, 0 write |
| addr | input | AW | Address of the request |
| wdata | input | DW | Write data of the request |
| timeout | input | TW | Cycles to wait for the slave strobe before aborting |
| grant | input | 1 | Bus grant from the external arbiter |
| busy | output | 1 | Master is handling a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last transfer timed out (valid with done) |
| rdata | output | DW | Data returned by the last read |
| reg_we | output | 1 | Slave local write strobe |
| reg_re | output | 1 | Slave local read strobe |
| reg_addr | output | OFF_W | Slave local register offset |
| reg_wdata | output | DW | Slave local write data |
| reg_rdata | input | DW | Slave local read data, combinational from reg_addr |
| bus_bbsy | output | 1 | Bus busy line |
| bus_msyn | output | 1 | Master strobe line |
| bus_ssyn | output | 1 | Slave strobe line |
| bus_cc | output | 1 | Direction code line |
| bus_addr | output | AW | Address lines |
| bus_data | output | DW | Data lines, the OR of the two drivers |

## Verification
The assertions assume that `start` comes only while `busy` is low. They also assume that `reg_rdata` is a pure function of `reg_addr` and is settled in the same cycle, and that `timeout` stays constant while a transfer runs. The bench respects all three. It pulses `start` only from idle and waits for done before the next request. It models the slave's registers as a small array read combinationally. It sets `timeout` between transfers.

// File: rtl/abus_pkg.sv
package abus_pkg;

    typedef enum logic [2:0] {
        M_IDLE,
        M_GRANT,
        M_ADDR,
        M_NEG
    } mst_state_e;

    typedef enum logic [0:0] {
        S_IDLE,
        S_ACK
    } slv_state_e;

endpackage

// File: rtl/abus_sync.sv
module abus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 0) begin : g_pass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] flop_q;
            for (genvar i = 0; i < STAGES; i++) begin : g_stage
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        flop_q[i] <= 1'b0;
                    end else if (i == 0) begin
                        flop_q[i] <= d;
                    end else begin
                        flop_q[i] <= flop_q[(i > 0) ? i - 1 : 0];
                    end
                end
            end
            assign q = flop_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/abus_master.sv
module abus_master
    import abus_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int TW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [TW-1:0] timeout,
    input  logic          grant,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rdata,
    output logic          bbsy,
    output logic          msyn,
    output logic          cc,
    output logic [AW-1:0] addr_out,
    output logic          m_drive,
    output logic [DW-1:0] m_data,
    input  logic          ssyn_in,
    input  logic [DW-1:0] data_in
);
    typedef struct packed {
        mst_state_e    st;
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [TW-1:0] cnt;
        logic          msyn;
        logic          bbsy;
        logic          drive;
        logic [DW-1:0] rdata;
        logic          err;
        logic          done;
    } mst_regs_t;

    mst_regs_t r_d, r_q;
    logic      ssyn_s;

    abus_sync #(.STAGES(SYNC_STAGES)) u_ssyn_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ssyn_in),
        .q     (ssyn_s)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            M_IDLE: begin
                if (start) begin
                    r_d.rd    = rd;
                    r_d.addr  = addr;
                    r_d.wdata = wdata;
                    r_d.err   = 1'b0;
                    r_d.st    = M_GRANT;
                end
            end
            M_GRANT: begin
                if (grant) begin
                    r_d.bbsy = 1'b1;
                    r_d.msyn = 1'b1;
                    r_d.cnt  = '0;
                    r_d.st   = M_ADDR;
                end
            end
            M_ADDR: begin
                if (ssyn_s) begin
                    if (r_q.rd) begin
                        r_d.rdata = data_in;
                    end else begin
                        r_d.drive = 1'b1;
                    end
                    r_d.msyn = 1'b0;
                    r_d.st   = M_NEG;
                end else if (r_q.cnt >= timeout) begin
                    r_d.msyn = 1'b0;
                    r_d.err  = 1'b1;
                    r_d.st   = M_NEG;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            M_NEG: begin
                if (!ssyn_s) begin
                    r_d.drive = 1'b0;
                    r_d.bbsy  = 1'b0;
                    r_d.done  = 1'b1;
                    r_d.st    = M_IDLE;
                end
            end
            default: r_d.st = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: M_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != M_IDLE);
    assign done     = r_q.done;
    assign err      = r_q.err;
    assign rdata    = r_q.rdata;
    assign bbsy     = r_q.bbsy;
    assign msyn     = r_q.msyn;
    assign cc       = r_q.bbsy & r_q.rd;
    assign addr_out = r_q.bbsy ? r_q.addr : '0;
    assign m_drive  = r_q.drive;
    assign m_data   = r_q.drive ? r_q.wdata : '0;

    AST_STROBE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        msyn |-> bbsy); // R1
    AST_STROBE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(msyn) |-> ($past(ssyn_s) || err)); // R4
    AST_DONE_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!msyn && !ssyn_in && !bbsy)); // R5
    AST_WDATA_AT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(msyn) && !err && !r_q.rd) |-> m_drive); // R2
endmodule

// File: rtl/abus_slave.sv
module abus_slave
    import abus_pkg::*;
#(
    parameter int            AW          = 16,
    parameter int            DW          = 16,
    parameter int            OFF_W       = 4,
    parameter logic [AW-1:0] BASE        = 16'h1230,
    parameter int            SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msyn_in,
    input  logic [AW-1:0]    addr_in,
    input  logic             cc_in,
    input  logic [DW-1:0]    data_in,
    output logic             ssyn,
    output logic             s_drive,
    output logic [DW-1:0]    s_data,
    output logic             reg_we,
    output logic             reg_re,
    output logic [OFF_W-1:0] reg_addr,
    output logic [DW-1:0]    reg_wdata,
    input  logic [DW-1:0]    reg_rdata
);
    localparam int HI_W = AW - OFF_W;

    typedef struct packed {
        slv_state_e     st;
        logic           ssyn;
        logic           drive;
        logic [DW-1:0]  sdata;
        logic           rd;
        logic [OFF_W-1:0] off;
        logic           we;
        logic [DW-1:0]  wdata;
    } slv_regs_t;

    slv_regs_t        r_d, r_q;
    logic             msyn_s;
    logic             hit;
    logic [OFF_W-1:0] bus_off;

    abus_sync #(.STAGES(SYNC_STAGES)) u_msyn_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (msyn_in),
        .q     (msyn_s)
    );

    assign hit     = (addr_in[AW-1:OFF_W] == BASE[AW-1:OFF_W]);
    assign bus_off = addr_in[OFF_W-1:0];

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (msyn_s && hit) begin
                    r_d.ssyn = 1'b1;
                    r_d.rd   = cc_in;
                    r_d.off  = bus_off;
                    if (cc_in) begin
                        r_d.sdata = reg_rdata;
                        r_d.drive = 1'b1;
                    end
                    r_d.st = S_ACK;
                end
            end
            S_ACK: begin
                if (!msyn_s) begin
                    r_d.ssyn  = 1'b0;
                    r_d.drive = 1'b0;
                    r_d.sdata = '0;
                    if (!r_q.rd) begin
                        r_d.we    = 1'b1;
                        r_d.wdata = data_in;
                    end
                    r_d.st = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ssyn      = r_q.ssyn;
    assign s_drive   = r_q.drive;
    assign s_data    = r_q.sdata;
    assign reg_we    = r_q.we;
    assign reg_re    = (r_q.st == S_IDLE) && msyn_s && hit && cc_in;
    assign reg_addr  = (r_q.st == S_IDLE) ? bus_off : r_q.off;
    assign reg_wdata = r_q.wdata;

    AST_ACK_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ssyn) |-> $past(msyn_s && (addr_in[AW-1:OFF_W] == BASE[AW-1:OFF_W]))); // R7
    AST_SSYN_DROP_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ssyn) |-> !$past(msyn_s)); // R4
    AST_READ_DATA_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ssyn) && $past(cc_in)) |-> s_drive); // R3
    AST_WRITE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (!ssyn && $past(ssyn))); // R2
endmodule

// File: rtl/abus_link.sv
module abus_link #(
    parameter int            AW          = 16,
    parameter int            DW          = 16,
    parameter int            TW          = 8,
    parameter int            OFF_W       = 4,
    parameter logic [AW-1:0] BASE        = 16'h1230,
    parameter int            SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rd,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [TW-1:0]    timeout,
    input  logic             grant,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [DW-1:0]    rdata,
    output logic             reg_we,
    output logic             reg_re,
    output logic [OFF_W-1:0] reg_addr,
    output logic [DW-1:0]    reg_wdata,
    input  logic [DW-1:0]    reg_rdata,
    output logic             bus_bbsy,
    output logic             bus_msyn,
    output logic             bus_ssyn,
    output logic             bus_cc,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_data
);
    logic          m_drive;
    logic [DW-1:0] m_data;
    logic          s_drive;
    logic [DW-1:0] s_data;

    assign bus_data = m_data | s_data;

    abus_master #(
        .AW(AW), .DW(DW), .TW(TW), .SYNC_STAGES(SYNC_STAGES)
    ) u_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rd       (rd),
        .addr     (addr),
        .wdata    (wdata),
        .timeout  (timeout),
        .grant    (grant),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .rdata    (rdata),
        .bbsy     (bus_bbsy),
        .msyn     (bus_msyn),
        .cc       (bus_cc),
        .addr_out (bus_addr),
        .m_drive  (m_drive),
        .m_data   (m_data),
        .ssyn_in  (bus_ssyn),
        .data_in  (bus_data)
    );

    abus_slave #(
        .AW(AW), .DW(DW), .OFF_W(OFF_W), .BASE(BASE), .SYNC_STAGES(SYNC_STAGES)
    ) u_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .msyn_in   (bus_msyn),
        .addr_in   (bus_addr),
        .cc_in     (bus_cc),
        .data_in   (bus_data),
        .ssyn      (bus_ssyn),
        .s_drive   (s_drive),
        .s_data    (s_data),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    AST_ONE_DATA_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_drive && s_drive)); // R2
    AST_CODE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cc |-> bus_bbsy); // R6
endmodule

// File: tb/abus_link_test.sv
module abus_link_test;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int TW = 8;
    localparam int OFF_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             rd = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic [DW-1:0]    wdata = '0;
    logic [TW-1:0]    timeout = 8'd20;
    logic             grant = 1'b1;
    logic             busy, done, err;
    logic [DW-1:0]    rdata;
    logic             reg_we, reg_re;
    logic [OFF_W-1:0] reg_addr;
    logic [DW-1:0]    reg_wdata, reg_rdata;
    logic             bus_bbsy, bus_msyn, bus_ssyn, bus_cc;
    logic [AW-1:0]    bus_addr;
    logic [DW-1:0]    bus_data;

    logic [DW-1:0] mem [16];
    int            wr_count = 0;
    int            total = 0;
    int            bad = 0;
    int            cyc = 0;

    always #5 clk = ~clk;

    abus_link uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd(rd), .addr(addr),
        .wdata(wdata), .timeout(timeout), .grant(grant), .busy(busy),
        .done(done), .err(err), .rdata(rdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .bus_bbsy(bus_bbsy), .bus_msyn(bus_msyn),
        .bus_ssyn(bus_ssyn), .bus_cc(bus_cc), .bus_addr(bus_addr),
        .bus_data(bus_data)
    );

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            wr_count <= wr_count + 1;
        end
        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One transfer with all ordering checks; grant_delay cycles of no grant.
    task automatic xfer(input bit r, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic [DW-1:0] exp_rd, input bit exp_err,
                        input int grant_delay);
        bit pm = 0, ps = 0, got_done = 0, saw_ssyn = 0;
        int hi = 0;
        int w0 = wr_count;
        @(negedge clk);
        grant = (grant_delay == 0);
        start = 1'b1; rd = r; addr = a; wdata = wd;
        @(negedge clk);
        start = 1'b0;
        for (int g = 0; g < grant_delay; g++) begin
            @(negedge clk);
            chk(!bus_msyn && !bus_bbsy && !bus_cc && bus_addr == '0, "R1",
                "lines idle before grant", {bus_msyn, bus_bbsy}, 0);
        end
        grant = 1'b1;
        for (int n = 0; n < 400 && !got_done; n++) begin
            @(negedge clk);
            if (bus_msyn) hi++;
            if (bus_ssyn) saw_ssyn = 1;
            if (bus_msyn && !pm) begin
                chk(bus_bbsy && bus_addr == a, "R1", "busy+addr with strobe",
                    {bus_bbsy, bus_addr}, {1'b1, a});
                chk(bus_cc == r, "R6", "direction code", bus_cc, r);
            end
            if (!bus_msyn && pm && !r && !exp_err)
                chk(bus_data == wd, "R2", "write data at strobe drop", bus_data, wd);
            if (bus_ssyn && !ps && r)
                chk(bus_data == exp_rd, "R3", "read data with slave strobe", bus_data, exp_rd);
            if (!bus_ssyn && ps)
                chk(!bus_msyn, "R4", "slave strobe drop after master drop", bus_msyn, 0);
            if (bus_ssyn && !ps && !r)
                chk(bus_msyn, "R4", "master strobe still high at ack", bus_msyn, 1);
            if (done) begin
                got_done = 1;
                chk(!bus_msyn && !bus_ssyn && !bus_bbsy, "R5", "quiet bus at done",
                    {bus_msyn, bus_ssyn, bus_bbsy}, 0);
                chk(err == exp_err, "R8", "error flag", err, exp_err);
                if (r && !exp_err)
                    chk(rdata == exp_rd, "R3", "returned read data", rdata, exp_rd);
            end
            pm = bus_msyn;
            ps = bus_ssyn;
        end
        chk(got_done, "R5", "done seen", got_done, 1);
        if (exp_err) begin
            chk(!saw_ssyn, "R7", "no slave strobe on foreign address", saw_ssyn, 0);
            chk(hi >= int'(timeout) && hi <= int'(timeout) + 2, "R8",
                "strobe high time on abort", hi, timeout);
        end
        repeat (2) @(negedge clk);
        if (!r && !exp_err) begin
            chk(wr_count == w0 + 1, "R2", "one local write", wr_count - w0, 1);
            chk(mem[a[OFF_W-1:0]] == wd, "R2", "stored word", mem[a[OFF_W-1:0]], wd);
        end else begin
            chk(wr_count == w0, "R8", "no local write", wr_count - w0, 0);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!bus_bbsy && !bus_msyn && !bus_ssyn && !bus_cc && bus_addr == '0 && bus_data == '0,
            "R9", "bus idle after reset", {bus_bbsy, bus_msyn, bus_ssyn}, 0);
        chk(!done && !busy && !reg_we, "R9", "local outputs idle", {done, busy, reg_we}, 0);
    endtask

    task automatic t_write_read;
        xfer(0, 16'h1235, 16'hBEEF, 0, 0, 0);
        xfer(1, 16'h1235, 0, 16'hBEEF, 0, 0);
    endtask

    task automatic t_grant_wait;
        xfer(0, 16'h1230, 16'h0A5A, 0, 0, 8);
        xfer(1, 16'h1230, 0, 16'h0A5A, 0, 6);
    endtask

    task automatic t_window_edges;
        xfer(0, 16'h123F, 16'hF00D, 0, 0, 0);
        xfer(1, 16'h123F, 0, 16'hF00D, 0, 0);
        xfer(1, 16'h1230, 0, 16'h0A5A, 0, 0);
    endtask

    task automatic t_foreign;
        timeout = 8'd12;
        xfer(0, 16'h1240, 16'h1111, 0, 1, 0);
        xfer(1, 16'h0235, 0, 0, 1, 0);
        timeout = 8'd20;
        xfer(1, 16'h1235, 0, 16'hBEEF, 0, 0);
    endtask

    task automatic t_back_to_back;
        for (int i = 0; i < 4; i++)
            xfer(0, 16'h1230 + i[15:0] + 16'd1, 16'h5000 + i[15:0], 0, 0, 0);
        for (int i = 0; i < 4; i++)
            xfer(1, 16'h1230 + i[15:0] + 16'd1, 0, 16'h5000 + i[15:0], 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_grant_wait();
        t_window_edges();
        t_foreign();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > 50000);
        chk(0, "R5", "watchdog expired", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule